// File: doc/BRIEF.md
# Fixed-Block Serial Command DMA

This block moves one fixed block of 64 bytes between main memory and the small command RAM of a serial peripheral controller. Software starts a transfer by writing a trigger strobe, and the direction select written with that strobe chooses the direction. The engine steps a byte index through the block and presents each byte on a valid/ready output stream. The selected source supplies that byte combinationally for the current index. The destination takes the byte when it asserts ready.

A command processor works on the command RAM, and it must run at the correct point in the transfer. When the block is loaded toward main memory, the engine first sends the command processor a one-cycle request and waits for its acknowledge, and only then copies. When the block is written toward the command RAM, the engine copies first and sends the request afterwards. A transfer ends by clearing the busy status and setting a sticky interrupt, which stays set until a clear input is pulsed.

The output stream follows valid/ready rules. Once `dst_valid` is high, it stays high, and `xfer_idx` and `dst_data` stay unchanged (given a source that is stable for a stable index), until a cycle in which `dst_ready` is high. A byte moves on every rising edge where both are high.

Top module: `sblk_dma`

## Requirements
- R1: After reset, `busy`, `irq`, `dst_valid` and `cmd_req` are all low.
- R2: A `trig_we` strobe while idle sets `busy` on the next edge. `trig_sel` = 0 selects command RAM to main memory, shown as `xfer_to_mem` = 1. `trig_sel` = 1 selects main memory to command RAM, shown as `xfer_to_mem` = 0.
- R3: Every transfer delivers exactly 64 bytes, with indices 0 to 63 in ascending order. Each byte carries `src_data` for its own index.
- R4: While `dst_valid` is high and `dst_ready` is low, the next cycle keeps `dst_valid` high and `xfer_idx` unchanged.
- R5: Toward main memory, `cmd_req` is issued before any byte is delivered. No byte is delivered before `cmd_ack` has been seen.
- R6: Toward the command RAM, `cmd_req` is issued only after all 64 bytes are accepted, and `busy` stays high until `cmd_ack` arrives.
- R7: `cmd_req` is high for exactly one cycle per transfer. A `cmd_ack` that arrives while no acknowledge is awaited has no effect.
- R8: `busy` clears and `irq` sets on the edge that accepts the last byte (toward main memory) or the edge that takes `cmd_ack` (toward the command RAM).
- R9: `irq` stays high until `irq_clr` is pulsed. If completion and `irq_clr` fall on the same edge, the interrupt stays set.
- R10: A `trig_we` strobe while `busy` is high is ignored. Direction, byte count and request count of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | Trigger strobe, one cycle |
| trig_sel | input | 1 | Direction select taken with the trigger |
| cmd_req | output | 1 | One-cycle request to the command processor |
| cmd_ack | input | 1 | Command processor finished |
| xfer_idx | output | 6 | Byte index being read and offered |
| xfer_to_mem | output | 1 | 1 when the destination is main memory |
| src_data | input | 8 | Source byte for `xfer_idx` |
| dst_valid | output | 1 | Byte on `dst_data` is valid |
| dst_ready | input | 1 | Destination accepts the byte |
| dst_data | output | 8 | Byte being delivered |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |
| irq_clr | input | 1 | Clears `irq` |

## Verification
A wrong sequencer state shows at the ports within a cycle. It appears as a request pulse at the wrong side of the copy, bytes leaving before the acknowledge, or `busy` falling one edge early or late against the final byte or acknowledge. A wrong byte counter appears as a skipped, repeated or 65th index in the output stream on the very beat where it diverges. A wrong interrupt latch appears as `irq` missing on the completion sample, or dropping without a clear, during the cycles right after a transfer.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CREQ  = 2'd1,
    ST_CWAIT = 2'd2,
    ST_COPY  = 2'd3
  } sdma_st_e;
endpackage

// File: rtl/sdma_beat_ctr.sv
module sdma_beat_ctr #(
  parameter int BLOCK_BYTES = 64,
  localparam int IDX_W = $clog2(BLOCK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx <= '0;
    else if (step) idx <= last ? '0 : idx + 1'b1;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last |=> idx == $past(idx) + 1'b1); // R3
endmodule

// File: rtl/sdma_irq_latch.sv
module sdma_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq); // R9
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_we,
  input  logic trig_sel,
  input  logic cmd_ack,
  input  logic beat_fire,
  input  logic beat_last,
  output logic busy,
  output logic to_mem,
  output logic cmd_req,
  output logic copying,
  output logic ctr_clr,
  output logic done
);
  sdma_st_e st;

  assign busy    = (st != ST_IDLE);
  assign cmd_req = (st == ST_CREQ);
  assign copying = (st == ST_COPY);
  assign ctr_clr = (st == ST_IDLE) && trig_we;
  assign done    = ((st == ST_CWAIT) && cmd_ack && !to_mem) ||
                   ((st == ST_COPY) && beat_fire && beat_last && to_mem);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      to_mem <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (trig_we) begin
          to_mem <= !trig_sel;
          st     <= trig_sel ? ST_COPY : ST_CREQ;
        end
        ST_CREQ:  st <= ST_CWAIT;
        ST_CWAIT: if (cmd_ack) st <= to_mem ? ST_COPY : ST_IDLE;
        ST_COPY:  if (beat_fire && beat_last) st <= to_mem ? ST_IDLE : ST_CREQ;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req); // R7
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig_we |=> $stable(to_mem)); // R10
endmodule

// File: rtl/sblk_dma.sv
module sblk_dma #(
  parameter int BLOCK_BYTES = 64,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic              trig_sel,
  output logic              cmd_req,
  input  logic              cmd_ack,
  output logic [IDX_W-1:0]  xfer_idx,
  output logic              xfer_to_mem,
  input  logic [DATA_W-1:0] src_data,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data,
  output logic              busy,
  output logic              irq,
  input  logic              irq_clr
);
  logic beat_fire, beat_last, copying, ctr_clr, done;

  assign dst_valid = copying;
  assign dst_data  = src_data;
  assign beat_fire = dst_valid && dst_ready;

  sdma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_sel(trig_sel),
    .cmd_ack(cmd_ack), .beat_fire(beat_fire), .beat_last(beat_last),
    .busy(busy), .to_mem(xfer_to_mem), .cmd_req(cmd_req),
    .copying(copying), .ctr_clr(ctr_clr), .done(done)
  );

  sdma_beat_ctr #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .step(beat_fire),
    .idx(xfer_idx), .last(beat_last)
  );

  sdma_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .set(done), .clr(irq_clr), .irq(irq)
  );

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=> dst_valid && $stable(xfer_idx)); // R4
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq && !busy); // R8
  AST_NO_BEAT_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !dst_valid); // R5
endmodule

// File: tb/sblk_dma_test.sv
module sblk_dma_test;
  logic clk = 0, rst_n = 0;
  logic trig_we = 0, trig_sel = 0, cmd_ack = 0, dst_ready = 1, irq_clr = 0;
  logic cmd_req, xfer_to_mem, dst_valid, busy, irq;
  logic [5:0] xfer_idx;
  logic [7:0] src_data, dst_data;

  int checks = 0, errors = 0;
  int beats, reqs, acks, scnt, last_evt, done_s, req_at_beats;
  int data_bad, idx_bad, hold_bad, dbl_req, early_beat;
  int ack_gap = 2, rdy_cnt = 0;
  bit stall = 0, mon_on = 0, exp_to_mem = 0, prev_req = 0, prev_stall = 0, busy_prev = 0;
  bit irq_at_done;
  logic [5:0] stall_idx;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(logic [5:0] i, bit m);
    return m ? 8'(i * 5 + 8'h21) : (8'hC3 ^ {2'b00, i});
  endfunction

  assign src_data = pat(xfer_idx, xfer_to_mem);

  sblk_dma uut (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_sel(trig_sel),
    .cmd_req(cmd_req), .cmd_ack(cmd_ack), .xfer_idx(xfer_idx),
    .xfer_to_mem(xfer_to_mem), .src_data(src_data), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_data(dst_data), .busy(busy), .irq(irq),
    .irq_clr(irq_clr)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // destination ready pattern
  initial forever begin
    @(negedge clk);
    rdy_cnt++;
    dst_ready = stall ? (rdy_cnt % 3 != 2) : 1'b1;
  end

  // command processor stub
  initial forever begin
    @(negedge clk); #1;
    if (cmd_req) begin
      repeat (ack_gap) @(negedge clk);
      cmd_ack = 1;
      @(negedge clk);
      cmd_ack = 0;
    end
  end

  // port monitor, sampled mid-cycle
  initial forever begin
    @(negedge clk); #1;
    if (mon_on) begin
      scnt++;
      if (prev_stall && !(dst_valid && xfer_idx == stall_idx)) hold_bad++;
      prev_stall = dst_valid && !dst_ready;
      stall_idx = xfer_idx;
      if (dst_valid && dst_ready) begin
        if (int'(xfer_idx) != beats) idx_bad++;
        if (dst_data != pat(xfer_idx, exp_to_mem) || xfer_to_mem != exp_to_mem) data_bad++;
        if (exp_to_mem && acks == 0) early_beat++;
        beats++;
        if (beats == 64 && exp_to_mem) last_evt = scnt;
      end
      if (cmd_req) begin
        if (prev_req) dbl_req++;
        reqs++;
        req_at_beats = beats;
      end
      prev_req = cmd_req;
      if (cmd_ack) begin
        acks++;
        if (!exp_to_mem) last_evt = scnt;
      end
      if (busy_prev && !busy && done_s < 0) begin
        done_s = scnt;
        irq_at_done = irq;
      end
      busy_prev = busy;
    end
  end

  task automatic run(bit sel, bit stl, int gap, bit retrig);
    beats = 0; reqs = 0; acks = 0; scnt = 0; last_evt = -100; done_s = -1;
    req_at_beats = -1; data_bad = 0; idx_bad = 0; hold_bad = 0; dbl_req = 0;
    early_beat = 0; prev_req = 0; prev_stall = 0; busy_prev = 0;
    exp_to_mem = !sel; stall = stl; ack_gap = gap; mon_on = 1;
    @(negedge clk);
    trig_we = 1; trig_sel = sel;
    @(negedge clk);
    trig_we = 0; #1;
    chk(busy == 1'b1, "R2 busy after trigger", busy, 1);
    chk(xfer_to_mem == !sel, "R2 direction", xfer_to_mem, !sel);
    if (retrig) begin
      repeat (12) @(negedge clk);
      trig_we = 1; trig_sel = !sel;
      @(negedge clk);
      trig_we = 0;
    end
    for (int k = 0; k < 2000 && done_s < 0; k++) @(negedge clk);
    #2;
    mon_on = 0;
    chk(beats == 64, "R3 byte count", beats, 64);
    chk(idx_bad == 0 && data_bad == 0, "R3 order/data", idx_bad + data_bad, 0);
    chk(reqs == 1 && dbl_req == 0, "R7 single request pulse", reqs, 1);
    chk(done_s == last_evt + 1, "R8 completion edge", done_s, last_evt + 1);
  endtask

  task automatic irq_release();
    repeat (3) @(negedge clk);
    #1 chk(irq == 1'b1, "R9 irq held", irq, 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0; #1;
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!busy && !irq && !dst_valid && !cmd_req, "R1 reset state",
        {busy, irq, dst_valid, cmd_req}, 0);
  endtask

  task automatic t_to_mem();
    run(1'b0, 1'b0, 3, 1'b0);
    chk(req_at_beats == 0, "R5 request before copy", req_at_beats, 0);
    chk(early_beat == 0, "R5 no byte before ack", early_beat, 0);
    chk(irq_at_done == 1'b1, "R8 irq at completion", irq_at_done, 1);
    irq_release();
  endtask

  task automatic t_to_cmd_stall();
    run(1'b1, 1'b1, 5, 1'b0);
    chk(hold_bad == 0, "R4 back-pressure hold", hold_bad, 0);
    chk(req_at_beats == 64, "R6 request after copy", req_at_beats, 64);
    chk(irq_at_done == 1'b1, "R8 irq at completion", irq_at_done, 1);
    irq_release();
  endtask

  task automatic t_retrig();
    run(1'b1, 1'b0, 4, 1'b1);
    chk(req_at_beats == 64, "R10 retrigger ignored, order kept", req_at_beats, 64);
    #1 chk(!busy, "R10 no second transfer", busy, 0);
    irq_release();
  endtask

  task automatic t_stray_ack();
    @(negedge clk); cmd_ack = 1;
    @(negedge clk); cmd_ack = 0; #1;
    chk(!busy && !dst_valid, "R7 stray ack while idle", busy, 0);
    run(1'b0, 1'b1, 6, 1'b0);
    chk(early_beat == 0, "R7 stray ack not reused", early_beat, 0);
    irq_release();
  endtask

  task automatic t_clr_race();
    irq_clr = 1;
    run(1'b0, 1'b0, 2, 1'b0);
    chk(irq_at_done == 1'b1, "R9 set wins over clear", irq_at_done, 1);
    @(negedge clk); #1;
    chk(irq == 1'b0, "R9 clear after set", irq, 0);
    irq_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_to_mem();
    t_to_cmd_stall();
    t_retrig();
    t_stray_ack();
    t_clr_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule